// File: doc/BRIEF.md
# Basis Blade Product Unit

This unit forms the geometric product of two weighted basis blades. Each operand is a blade given as a bitmap of basis vectors (bit i set means basis vector i is a factor) together with a signed fixed-point coefficient. The unit returns the bitmap of the result blade, the sign the product picks up from the algebra, and the signed coefficient of the product term. It sits ahead of an accumulator in a multivector engine. Every cycle with a valid pair produces one term, one cycle later.

The result blade is the XOR of the two bitmaps. The algebraic sign has two parts. The first comes from the vector swaps needed to bring the concatenated factors into ascending order. The second comes from shared factors that square to -1, as marked in a signature register. Both are parity functions built from AND/XOR gate cascades. No product table is used. The coefficient product is scaled back to the operand format by an arithmetic right shift of FRAC bits and truncated. It is negated in two's complement when the algebraic sign is negative.

The space dimension DIM is a parameter from 1 to 8. Blade fields are always 8 bits wide. Bitmap bits at position DIM and above are outside the space.

Top module: `bbp_blade_product`

## Requirements
- R1: `out_blade` equals the bitwise XOR of the two input bitmaps, after both are masked to bits 0..DIM-1.
- R2: Input bitmap bits at positions DIM..7 have no effect on any output, and `out_blade` bits DIM..7 are always 0.
- R3: The reorder sign is the parity of the number of pairs (i, j) where bit i is set in A, bit j is set in B, and i > j.
- R4: The signature sign is the parity of popcount(A & B & S), where S is the signature register. A 1 in bit i of S means basis vector i squares to -1.
- R5: `out_blade_neg` is the XOR of the R3 and R4 parities. `out_coef` is the low 32 bits of (A_coef * B_coef) >>> FRAC, computed as a signed full-width product with an arithmetic shift. When `out_blade_neg` is 1, `out_coef` is the two's-complement negation of that value, modulo 2^32.
- R6: `out_sign` equals `out_blade_neg` XOR bit 31 of `in_coef_a` XOR bit 31 of `in_coef_b`.
- R7: A pair presented with `in_valid`=1 at a rising edge appears on the outputs after that edge, with `out_valid`=1. `out_valid` is 0 after any edge where `in_valid` was 0.
- R8: After an edge with `in_valid`=0, `out_blade`, `out_coef`, `out_blade_neg` and `out_sign` keep their previous values.
- R9: When `sig_wr_en`=1 at an edge, the signature register loads `sig_wr_data` at that edge. A product sampled at the same edge still uses the old signature.
- R10: Reset (`rst_n`=0, asynchronous) clears `out_valid`, `out_blade`, `out_coef`, `out_blade_neg` and `out_sign` to 0. It also clears the signature register to all zeros, so every basis vector squares to +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_blade_a | input | 8 | Bitmap of blade A |
| in_coef_a | input | 32 | Signed coefficient of A |
| in_blade_b | input | 8 | Bitmap of blade B |
| in_coef_b | input | 32 | Signed coefficient of B |
| sig_wr_en | input | 1 | Load the signature register |
| sig_wr_data | input | DIM | New signature, 1 = squares to -1 |
| out_valid | output | 1 | Result term present |
| out_blade | output | 8 | Bitmap of the result blade |
| out_coef | output | 32 | Signed coefficient of the result term |
| out_blade_neg | output | 1 | Algebraic sign (reorder XOR signature) |
| out_sign | output | 1 | Combined sign including coefficient signs |

## Verification
Every result is due exactly one rising edge after the pair that produced it. A signature write takes effect on the first pair sampled at the following edge. The bench drives inputs on falling edges. Its reference model computes each term from the inputs and its own copy of the signature at the rising edge, and the bench compares every output field on the next falling edge. Directed cases then check, at that same falling edge, the reorder sign, the signature sign, the same-edge signature write, out-of-range bitmap bits, holding of outputs, and the fixed-point truncation.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
    localparam int BLADE_W = 8;
    localparam int MAX_DIM = 8;
    typedef logic [BLADE_W-1:0] blade_t;

    function automatic blade_t dim_mask(input int dim);
        dim_mask = BLADE_W'((1 << dim) - 1);
    endfunction
endpackage

// File: rtl/bbp_swap_parity.sv
module bbp_swap_parity #(
    parameter int N = 8
) (
    input  logic [N-1:0] blade_a,
    input  logic [N-1:0] blade_b,
    output logic         odd
);
    // sfx[k] = parity of blade_a[N-1:k]; sfx[N] = 0
    logic [N:0]   sfx;
    logic [N-1:0] term;

    assign sfx[N] = 1'b0;

    genvar k;
    generate
        for (k = N - 1; k >= 0; k--) begin : g_chain
            assign sfx[k]  = sfx[k+1] ^ blade_a[k];
            // vectors of A above position k that must hop over b_k
            assign term[k] = blade_b[k] & sfx[k+1];
        end
    endgenerate

    assign odd = ^term;
endmodule

// File: rtl/bbp_metric_parity.sv
module bbp_metric_parity #(
    parameter int N = 8
) (
    input  logic [N-1:0] blade_a,
    input  logic [N-1:0] blade_b,
    input  logic [N-1:0] sig,
    output logic         odd
);
    logic [N-1:0] hit;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_hit
            assign hit[k] = blade_a[k] & blade_b[k] & sig[k];
        end
    endgenerate

    assign odd = ^hit;
endmodule

// File: rtl/bbp_coef_scale.sv
module bbp_coef_scale #(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic [W-1:0] coef_a,
    input  logic [W-1:0] coef_b,
    input  logic         negate,
    output logic [W-1:0] coef_out
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] full;
    logic        [W-1:0]  trunc;

    assign full     = PW'($signed(coef_a)) * PW'($signed(coef_b));
    assign trunc    = W'(full >>> FRAC);
    assign coef_out = negate ? (~trunc + W'(1)) : trunc;
endmodule

// File: rtl/bbp_sig_reg.sv
module bbp_sig_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] sig_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (wr_en) begin
            sig_q <= wr_data;
        end
    end
endmodule

// File: rtl/bbp_blade_product.sv
module bbp_blade_product #(
    parameter int DIM    = 8,
    parameter int COEF_W = 32,
    parameter int FRAC   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [bbp_pkg::BLADE_W-1:0] in_blade_a,
    input  logic [COEF_W-1:0]         in_coef_a,
    input  logic [bbp_pkg::BLADE_W-1:0] in_blade_b,
    input  logic [COEF_W-1:0]         in_coef_b,
    input  logic                      sig_wr_en,
    input  logic [DIM-1:0]            sig_wr_data,
    output logic                      out_valid,
    output logic [bbp_pkg::BLADE_W-1:0] out_blade,
    output logic [COEF_W-1:0]         out_coef,
    output logic                      out_blade_neg,
    output logic                      out_sign
);
    import bbp_pkg::*;

    localparam blade_t DMASK = dim_mask(DIM);

    blade_t              a_m;
    blade_t              b_m;
    logic [DIM-1:0]      sig_q;
    logic                swap_odd;
    logic                metric_odd;
    logic                neg_c;
    logic [COEF_W-1:0]   coef_c;
    logic                sign_c;

    assign a_m = in_blade_a & DMASK;
    assign b_m = in_blade_b & DMASK;

    bbp_sig_reg #(.N(DIM)) u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sig_wr_en),
        .wr_data (sig_wr_data),
        .sig_q   (sig_q)
    );

    bbp_swap_parity #(.N(DIM)) u_swap (
        .blade_a (a_m[DIM-1:0]),
        .blade_b (b_m[DIM-1:0]),
        .odd     (swap_odd)
    );

    bbp_metric_parity #(.N(DIM)) u_metric (
        .blade_a (a_m[DIM-1:0]),
        .blade_b (b_m[DIM-1:0]),
        .sig     (sig_q),
        .odd     (metric_odd)
    );

    assign neg_c = swap_odd ^ metric_odd;

    bbp_coef_scale #(.W(COEF_W), .FRAC(FRAC)) u_scale (
        .coef_a   (in_coef_a),
        .coef_b   (in_coef_b),
        .negate   (neg_c),
        .coef_out (coef_c)
    );

    assign sign_c = neg_c ^ in_coef_a[COEF_W-1] ^ in_coef_b[COEF_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_blade     <= '0;
            out_coef      <= '0;
            out_blade_neg <= 1'b0;
            out_sign      <= 1'b0;
        end else if (in_valid) begin
            out_blade     <= a_m ^ b_m;
            out_coef      <= coef_c;
            out_blade_neg <= neg_c;
            out_sign      <= sign_c;
        end
    end
endmodule

// File: rtl/bbp_blade_product_chk.sv
module bbp_blade_product_chk #(
    parameter int DIM    = 8,
    parameter int COEF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        in_blade_a,
    input logic [COEF_W-1:0] in_coef_a,
    input logic [7:0]        in_blade_b,
    input logic [COEF_W-1:0] in_coef_b,
    input logic              sig_wr_en,
    input logic [DIM-1:0]    sig_wr_data,
    input logic [DIM-1:0]    sig_q,
    input logic              out_valid,
    input logic [7:0]        out_blade,
    input logic [COEF_W-1:0] out_coef,
    input logic              out_blade_neg,
    input logic              out_sign
);
    localparam logic [7:0] MASK = bbp_pkg::dim_mask(DIM);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_blade) && $stable(out_coef) && $stable(out_blade_neg) && $stable(out_sign))); // R8
    AST_BLADE_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_blade == $past((in_blade_a ^ in_blade_b) & MASK)); // R1
    AST_NO_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_blade & ~MASK) == 8'h00); // R2
    AST_SCALAR_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_blade_a & MASK) == 8'h00) |=> !out_blade_neg); // R3 R4
    AST_SIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sig_wr_en |=> sig_q == $past(sig_wr_data)); // R9
    AST_SIGN_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_sign == (out_blade_neg ^ $past(in_coef_a[COEF_W-1]) ^ $past(in_coef_b[COEF_W-1]))); // R6
endmodule

bind bbp_blade_product bbp_blade_product_chk #(.DIM(DIM), .COEF_W(COEF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_blade_a    (in_blade_a),
    .in_coef_a     (in_coef_a),
    .in_blade_b    (in_blade_b),
    .in_coef_b     (in_coef_b),
    .sig_wr_en     (sig_wr_en),
    .sig_wr_data   (sig_wr_data),
    .sig_q         (sig_q),
    .out_valid     (out_valid),
    .out_blade     (out_blade),
    .out_coef      (out_coef),
    .out_blade_neg (out_blade_neg),
    .out_sign      (out_sign)
);

// File: tb/sim_bbp_blade_product.sv
`timescale 1ns/1ps
module sim_bbp_blade_product;
    localparam int DIM  = 6;
    localparam int FRAC = 16;
    localparam logic [7:0] MASK = 8'((1 << DIM) - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_blade_a = '0, in_blade_b = '0;
    logic [31:0] in_coef_a = '0, in_coef_b = '0;
    logic        sig_wr_en = 1'b0;
    logic [DIM-1:0] sig_wr_data = '0;
    logic        out_valid;
    logic [7:0]  out_blade;
    logic [31:0] out_coef;
    logic        out_blade_neg, out_sign;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bbp_blade_product #(.DIM(DIM), .COEF_W(32), .FRAC(FRAC)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_blade_a(in_blade_a), .in_coef_a(in_coef_a),
        .in_blade_b(in_blade_b), .in_coef_b(in_coef_b),
        .sig_wr_en(sig_wr_en), .sig_wr_data(sig_wr_data),
        .out_valid(out_valid), .out_blade(out_blade), .out_coef(out_coef),
        .out_blade_neg(out_blade_neg), .out_sign(out_sign)
    );

    // reference model state
    logic           m_valid, m_neg, m_sign;
    logic [7:0]     m_blade;
    logic [31:0]    m_coef;
    logic [DIM-1:0] m_sig;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid = 0; m_neg = 0; m_sign = 0; m_blade = 0; m_coef = 0; m_sig = '0;
        end else begin
            m_valid = in_valid;
            if (in_valid) begin
                int pairs;
                int shared;
                longint pa;
                longint sh;
                logic [31:0] tr;
                logic [7:0] am, bm;
                am = in_blade_a & MASK;
                bm = in_blade_b & MASK;
                pairs = 0;
                shared = 0;
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < i; j++)
                        if (am[i] && bm[j]) pairs++;
                for (int i = 0; i < DIM; i++)
                    if (am[i] && bm[i] && m_sig[i]) shared++;
                pa = longint'($signed(in_coef_a)) * longint'($signed(in_coef_b));
                sh = pa >>> FRAC;
                tr = sh[31:0];
                m_blade = am ^ bm;
                m_neg = ((pairs + shared) % 2) == 1;
                m_coef = m_neg ? (32'd0 - tr) : tr;
                m_sign = m_neg ^ in_coef_a[31] ^ in_coef_b[31];
            end
            if (sig_wr_en) m_sig = sig_wr_data;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 out_valid", out_valid, m_valid);
            chk("R1 R2 out_blade", out_blade, m_blade);
            chk("R3 R4 out_blade_neg", out_blade_neg, m_neg);
            chk("R5 out_coef", out_coef, m_coef);
            chk("R6 out_sign", out_sign, m_sign);
        end
    end

    // present one pair on a falling edge; return on the falling edge after it is captured
    task automatic op(input logic [7:0] a, input logic [31:0] ca,
                      input logic [7:0] b, input logic [31:0] cb);
        in_valid = 1; in_blade_a = a; in_coef_a = ca; in_blade_b = b; in_coef_b = cb;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset out_valid", out_valid, 0);
        chk("R10 reset out_blade", out_blade, 0);
        chk("R10 reset out_coef", out_coef, 0);
        rst_n = 1;
        @(negedge clk);
        // R10: signature resets to Euclidean, e0*e0 positive
        op(8'h01, 32'h0001_0000, 8'h01, 32'h0001_0000);
        chk("R10 sig reset neg", out_blade_neg, 0);
        chk("R10 sig reset coef", out_coef, 32'h0001_0000);
        // R3: e1*e0 needs one swap
        op(8'h02, 32'h0001_0000, 8'h01, 32'h0001_0000);
        chk("R3 swap blade", out_blade, 8'h03);
        chk("R3 swap neg", out_blade_neg, 1);
        chk("R3 swap coef", out_coef, 32'hFFFF_0000);
        chk("R6 swap sign", out_sign, 1);
        // R8: idle cycle keeps data, valid drops
        @(negedge clk);
        chk("R8 hold blade", out_blade, 8'h03);
        chk("R8 hold coef", out_coef, 32'hFFFF_0000);
        chk("R7 valid drop", out_valid, 0);
        // R4: e2 squares to -1
        sig_wr_en = 1; sig_wr_data = 6'b000100;
        @(negedge clk);
        sig_wr_en = 0;
        op(8'h04, 32'h0002_0000, 8'h04, 32'h0001_0000);
        chk("R4 metric blade", out_blade, 8'h00);
        chk("R4 metric neg", out_blade_neg, 1);
        chk("R4 metric coef", out_coef, 32'hFFFE_0000);
        // R9: write on the same edge as a product uses the old signature
        sig_wr_en = 1; sig_wr_data = '0;
        op(8'h04, 32'h0001_0000, 8'h04, 32'h0001_0000);
        sig_wr_en = 0;
        chk("R9 same-edge old sig", out_blade_neg, 1);
        op(8'h04, 32'h0001_0000, 8'h04, 32'h0001_0000);
        chk("R9 new sig applied", out_blade_neg, 0);
        // R2: bits above DIM ignored
        op(8'hC1, 32'h0001_0000, 8'h80, 32'h0001_0000);
        chk("R2 high bits blade", out_blade, 8'h01);
        chk("R2 high bits neg", out_blade_neg, 0);
        // R5: truncation of 1.5 * -1.0
        op(8'h00, 32'h0001_8000, 8'h00, 32'hFFFF_0000);
        chk("R5 trunc coef", out_coef, 32'hFFFE_8000);
        chk("R6 trunc sign", out_sign, 1);
        // R5: small product truncates toward minus infinity
        op(8'h00, 32'h0000_0001, 8'h00, 32'hFFFF_FFFF);
        chk("R5 floor coef", out_coef, 32'hFFFF_FFFF);
        // random traffic, compared every cycle by the model
        for (int n = 0; n < 3000; n++) begin
            in_valid = ($urandom % 4) != 0;
            in_blade_a = 8'($urandom);
            in_blade_b = 8'($urandom);
            in_coef_a = $urandom;
            in_coef_b = ($urandom % 3 == 0) ? 32'($urandom % 65536) : $urandom;
            sig_wr_en = ($urandom % 16) == 0;
            sig_wr_data = DIM'($urandom);
            @(negedge clk);
        end
        in_valid = 0; sig_wr_en = 0;
        @(negedge clk);
        finish_up();
    end
endmodule